// File: doc/BRIEF.md
# Half-Precision to Single-Precision Widener

This block converts a 16-bit half-precision operand to a 32-bit IEEE single-precision value. The conversion is exact: every half value, including subnormals, can be represented in single precision, so no rounding logic is needed. The block is a single pipeline stage. Whatever is on the inputs at a rising clock edge appears, converted, on the outputs after that edge.

Two controls set the interpretation. The alternative-range control makes the top exponent code an ordinary finite exponent, so the half format has no infinities and no NaNs in that mode. The default-NaN control replaces any NaN result with the canonical quiet NaN. A signalling NaN input raises the invalid flag. When default-NaN is off, the NaN is quieted and its payload is kept.

Top module: `half_widen`

## Requirements
- R1: The outputs are registered. The result and flag for the inputs sampled at one rising edge appear after that edge. While rst_n is low, the result and the flag are both zero.
- R2: Input fields are sign in bit 15, exponent in bits 14:10 and fraction in bits 9:0. For a normal input (exponent 1..30), the output exponent is the input exponent plus 112 and the output fraction is the input fraction shifted left by 13. The flag stays low.
- R3: For a subnormal input (exponent 0, fraction nonzero), the output is normalised. If the leading one of the fraction is at bit p, the output exponent is p+103. The output fraction is the fraction bits below p, placed left-aligned in the 23-bit field. The flag stays low.
- R4: A zero input gives a zero output with the same sign. The flag stays low.
- R5: In IEEE mode (alt_range=0), exponent 31 with fraction 0 gives a signed infinity: exponent 0xFF and fraction 0.
- R6: In IEEE mode, exponent 31 with fraction bit 9 set is a quiet NaN. When default-NaN is off, the output is exponent 0xFF with the input fraction shifted left by 13, and the flag stays low.
- R7: In IEEE mode, exponent 31 with a nonzero fraction and fraction bit 9 clear is a signalling NaN. It raises the invalid flag. When default-NaN is off, the output keeps the payload and sets the quiet bit (output bit 22).
- R8: With dflt_nan=1, every NaN input gives 0x7FC00000, which has a positive sign and an empty payload. The flag still follows R7. Non-NaN inputs are not affected by this control.
- R9: With alt_range=1, exponent 31 is a finite normal exponent. It gives output exponent 143 and the fraction shifted left by 13. The flag is never raised in this mode.
- R10: The output sign equals the input sign in every case except the default NaN of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_in | input | 16 | Half-precision operand |
| alt_range | input | 1 | 1: exponent 31 is finite; 0: IEEE specials |
| dflt_nan | input | 1 | 1: NaN results become the canonical quiet NaN |
| single_out | output | 32 | Single-precision result |
| invalid | output | 1 | Signalling NaN seen in the previous operand |

## Verification
On every cycle, the assertions check the following:
- sign transfer;
- signed zeros;
- infinities;
- the invalid flag for signalling NaNs;
- the canonical default NaN;
- finite treatment of exponent 31 in alternative mode.

The exact output bit patterns can only be shown by the bench's directed scenarios. This covers the placement of the normalised subnormal fraction, the rebiased exponents at the ends of the range and the preserved NaN payloads. These scenarios compare against hand-derived constants.

// File: rtl/half_widen.sv
module half_widen #(
  parameter int HW = 16,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] half_in,
  input  logic          alt_range,
  input  logic          dflt_nan,
  output logic [SW-1:0] single_out,
  output logic          invalid
);
  localparam int HF = 10;
  localparam int SF = 23;
  localparam int SH = SF - HF;
  localparam int REBIAS = 112;

  logic          sgn;
  logic [4:0]    hexp;
  logic [HF-1:0] hfrac;
  assign sgn   = half_in[HW-1];
  assign hexp  = half_in[HW-2:HF];
  assign hfrac = half_in[HF-1:0];

  logic is_top, is_nan, is_snan;
  assign is_top  = (hexp == 5'h1f) && !alt_range;
  assign is_nan  = is_top && (hfrac != '0);
  assign is_snan = is_nan && !hfrac[HF-1];

  logic [3:0] lead;
  always_comb begin
    lead = '0;
    for (int i = 0; i < HF; i++)
      if (hfrac[i]) lead = 4'(i);
  end

  logic [SF+HF-1:0] shifted;
  assign shifted = {{SF{1'b0}}, hfrac} << (SF - int'(lead));

  logic [SW-1:0] res;
  always_comb begin
    if (hexp == '0 && hfrac == '0)
      res = {sgn, {(SW-1){1'b0}}};
    else if (hexp == '0)
      res = {sgn, 8'(int'(lead) + 103), shifted[SF-1:0]};
    else if (is_nan && dflt_nan)
      res = 32'h7fc0_0000;
    else if (is_nan)
      res = {sgn, 8'hff, 1'b1, hfrac[HF-2:0], {SH{1'b0}}};
    else if (is_top)
      res = {sgn, 8'hff, {SF{1'b0}}};
    else
      res = {sgn, 8'(int'(hexp) + REBIAS), hfrac, {SH{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_out <= '0;
      invalid    <= 1'b0;
    end else begin
      single_out <= res;
      invalid    <= is_snan;
    end
  end

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_in[14:0] == '0) |=> (single_out == {$past(half_in[15]), 31'b0}) && !invalid);

  p_inf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_range && half_in[14:0] == 15'h7c00) |=> (single_out[30:0] == 31'h7f80_0000));

  p_snan_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_range && half_in[14:10] == 5'h1f && !half_in[9] && half_in[8:0] != '0) |=> invalid);

  p_dnan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dflt_nan && !alt_range && half_in[14:10] == 5'h1f && half_in[9:0] != '0)
      |=> single_out == 32'h7fc0_0000);

  p_alt_finite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_range && half_in[14:10] == 5'h1f) |=> (single_out[30:23] == 8'd143) && !invalid);

  p_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dflt_nan && !alt_range && half_in[14:10] == 5'h1f && half_in[9:0] != '0)
      |=> single_out[31] == $past(half_in[15]));
endmodule

// File: tb/tb_half_widen.sv
module tb_half_widen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] half_in = '0;
  logic        alt_range = 1'b0;
  logic        dflt_nan = 1'b0;
  logic [31:0] single_out;
  logic        invalid;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  half_widen dut (.clk(clk), .rst_n(rst_n), .half_in(half_in), .alt_range(alt_range),
                  .dflt_nan(dflt_nan), .single_out(single_out), .invalid(invalid));

  task automatic conv(input string req, input logic [15:0] h, input logic alt, input logic dn,
                      input logic [31:0] exp_v, input logic exp_f);
    @(negedge clk);
    half_in = h; alt_range = alt; dflt_nan = dn;
    @(negedge clk);
    n_chk++;
    if (single_out !== exp_v || invalid !== exp_f) begin
      n_bad++;
      $display("FAIL %s in=%h: got %h/%b expected %h/%b", req, h, single_out, invalid, exp_v, exp_f);
    end
  endtask

  task automatic t_reset;
    half_in = 16'h3c00;
    repeat (3) @(negedge clk);
    n_chk++;
    if (single_out !== '0 || invalid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got %h/%b expected 00000000/0", single_out, invalid);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_normal;
    conv("R2", 16'h3c00, 0, 0, 32'h3f80_0000, 0);
    conv("R2", 16'hc000, 0, 0, 32'hc000_0000, 0);
    conv("R2", 16'h7bff, 0, 0, 32'h477f_e000, 0);
    conv("R2", 16'h0400, 0, 0, 32'h3880_0000, 0);
  endtask

  task automatic t_subnormal;
    conv("R3", 16'h0001, 0, 0, 32'h3380_0000, 0);
    conv("R3", 16'h03ff, 0, 0, 32'h387f_c000, 0);
    conv("R3", 16'h8200, 0, 0, 32'hb800_0000, 0);
  endtask

  task automatic t_zero;
    conv("R4", 16'h0000, 0, 0, 32'h0000_0000, 0);
    conv("R4", 16'h8000, 1, 1, 32'h8000_0000, 0);
  endtask

  task automatic t_specials;
    conv("R5", 16'h7c00, 0, 0, 32'h7f80_0000, 0);
    conv("R5", 16'hfc00, 0, 1, 32'hff80_0000, 0);
    conv("R6", 16'h7e01, 0, 0, 32'h7fc0_2000, 0);
    conv("R7", 16'h7d00, 0, 0, 32'h7fe0_0000, 1);
    conv("R7 R10", 16'hfc01, 0, 0, 32'hffc0_2000, 1);
  endtask

  task automatic t_default_nan;
    conv("R8", 16'h7d00, 0, 1, 32'h7fc0_0000, 1);
    conv("R8", 16'hfe00, 0, 1, 32'h7fc0_0000, 0);
    conv("R8", 16'h3c00, 0, 1, 32'h3f80_0000, 0);
  endtask

  task automatic t_alt;
    conv("R9", 16'h7c00, 1, 0, 32'h4780_0000, 0);
    conv("R9", 16'h7fff, 1, 1, 32'h47ff_e000, 0);
    conv("R9 R10", 16'hfd00, 1, 0, 32'hc7a0_0000, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_normal();
        t_subnormal();
        t_zero();
        t_specials();
        t_default_nan();
        t_alt();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule